// File: doc/BRIEF.md
# Per-Bucket Bloom Filter Dedup Lookup Engine

This block decides whether a page fingerprint is already held in a chained hash table of page metadata. The low bits of the fingerprint pick a bucket. Each bucket keeps its own 64-bit plain-bit Bloom filter and a linked list of entries in an external memory. When a probe misses the bucket's filter, the page is new and no memory is read. When a probe hits the filter, the bucket's chain is walked from its head, one read per entry, until a stored fingerprint matches or the chain ends.

The block serves three operations: lookup, insert (lookup followed by an append when the page is new) and erase (unlink). A filter has no counters, so an erase leaves its bits set. Stale bits are removed when a walk ends with no match. During every walk the engine collects a shadow filter from the fingerprints it reads. If the walk ends without a match, that shadow replaces the bucket's filter, so the rebuild costs no extra memory reads. Only one request is in flight at a time.

The controller has these states:
- IDLE: accept a request.
- PROBE: test the filter.
- FETCH: issue an entry read.
- CHECK: compare the entry, then follow its link or stop.
- UNLINK: rewrite the predecessor of an erased entry.
- TAIL_RD and TAIL_WR: read the old tail, then write it back linked to the new entry.
- NEW_WR: write the new entry and set its filter bits.
- RESP: one response cycle.

The transitions are:
- IDLE→PROBE on an accepted request.
- PROBE→FETCH on a filter hit with a non-empty bucket.
- PROBE→RESP on a miss for lookup or erase.
- PROBE→TAIL_RD, NEW_WR or RESP (table full) on a miss for insert.
- FETCH→CHECK.
- CHECK→FETCH while the entry does not match and has a link.
- CHECK→UNLINK when an erase matches a non-head entry.
- CHECK→RESP on a match, or at the chain end for lookup or erase.
- CHECK→TAIL_RD, NEW_WR or RESP at the chain end for insert.
- TAIL_RD→TAIL_WR→NEW_WR→RESP.
- UNLINK→RESP.
- RESP→IDLE.

Top module: `dedup_bf_engine`

## Requirements
- R1: After reset, `req_ready_o` is 1, `resp_valid_o` is 0, no memory access is made, every filter is empty, every bucket is empty, and the next free entry index is 0.
- R2: With the default parameters, the bucket is fingerprint bits [3:0]. The three filter positions are bits [9:4], [15:10] and [21:16]. Each bucket has its own filter, so entries in one bucket never cause a walk in another bucket.
- R3: If any of the three positions is clear in the bucket's filter, the response is made without reading memory. The status is NEW for lookup and NOTFOUND for erase.
- R4: On a filter hit, the chain is read from the head in append order, one read per entry, and the walk stops at the first fingerprint equal to the request. Lookup and insert then respond DUP with that entry's index.
- R5: If a filter hit ends at the chain end with no match, the bucket's filter is replaced by the OR of the positions of the entries just read. No extra reads are made, and a later probe that relied only on cleared bits makes no reads.
- R6: An insert of a new page does the following:
  - It writes the entry at the next free index. Indices are handed out 0, 1, 2, … and never reused.
  - It appends the entry to the chain tail, which costs one read of the old tail when the bucket is not empty.
  - It sets the entry's three filter bits.
  - It responds NEW with the entry's index.
- R7: When all entries are used, an insert of a new page responds FULL and changes no chain.
- R8: An erase that matches unlinks the entry and responds ERASED with its index. The entry's filter bits stay set, so a later lookup of that fingerprint still walks the chain.
- R9: Requests are taken only while `req_ready_o` is 1 (IDLE). Each accepted request gives exactly one single-cycle response, after which the block is ready again. Lookups never write memory.
- R10: The operation codes are 0 lookup, 1 insert and 2 erase, and code 3 acts as lookup. The status codes are 0 NEW, 1 DUP, 2 ERASED, 3 NOTFOUND and 4 FULL.
- R11: A memory word holds the fingerprint in bits [FP_W-1:0], the next index above it, and a link-valid flag in the top bit. Read data is valid in the cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Engine idle, request taken on this edge |
| req_op_i | input | 2 | Operation code |
| req_fp_i | input | FP_W | Page fingerprint |
| resp_valid_o | output | 1 | Response strobe, one cycle |
| resp_status_o | output | 3 | Response status code |
| resp_idx_o | output | IDX_W | Entry index for DUP, ERASED and inserted NEW |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Memory write (else read) |
| mem_addr_o | output | IDX_W | Entry index addressed |
| mem_wdata_o | output | FP_W+IDX_W+1 | Entry word written |
| mem_rdata_i | input | FP_W+IDX_W+1 | Entry word read, one cycle after the request |

## Verification
The bench targets fingerprints built to share a bucket and all three filter positions but differ in their upper bits. These force false positives. A design that failed to rebuild on such a miss would keep walking on later probes, and the bench catches this through the exact read count it expects for every request. Erasing a head, a middle entry and a tail checks the relinking: a wrong predecessor rewrite or tail update shows up as a later walk with the wrong length or a wrong DUP index. Filling the table to its last entry checks the FULL boundary, where an off-by-one either loses the final entry or overwrites entry 0. Code 3 and an erase of an absent page check the encoding paths.

// File: rtl/dedup_bf_pkg.sv
package dedup_bf_pkg;

    typedef enum logic [1:0] {
        OP_LOOKUP = 2'd0,
        OP_INSERT = 2'd1,
        OP_ERASE  = 2'd2,
        OP_RSVD   = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_NEW      = 3'd0,
        ST_DUP      = 3'd1,
        ST_ERASED   = 3'd2,
        ST_NOTFOUND = 3'd3,
        ST_FULL     = 3'd4
    } status_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PROBE,
        S_FETCH,
        S_CHECK,
        S_UNLINK,
        S_TAIL_RD,
        S_TAIL_WR,
        S_NEW_WR,
        S_RESP
    } state_e;

endpackage

// File: rtl/dedup_bf_hash.sv
// Turns K position fields into a K-hot filter mask.
module dedup_bf_hash #(
    parameter int FLT_W = 64,
    parameter int K     = 3,
    localparam int POS_W = $clog2(FLT_W)
) (
    input  logic [K*POS_W-1:0] sel,
    output logic [FLT_W-1:0]   mask
);
    logic [FLT_W-1:0] onehot [K];

    for (genvar k = 0; k < K; k++) begin : g_pos
        assign onehot[k] = FLT_W'(1) << sel[k*POS_W +: POS_W];
    end

    always_comb begin
        mask = '0;
        for (int k = 0; k < K; k++) begin
            mask = mask | onehot[k];
        end
    end
endmodule

// File: rtl/dedup_bf_bank.sv
// One plain-bit filter per bucket; OR-in or full replace on write.
module dedup_bf_bank #(
    parameter int NBKT  = 16,
    parameter int FLT_W = 64,
    localparam int BKT_W = $clog2(NBKT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BKT_W-1:0] rd_bkt,
    input  logic [FLT_W-1:0] probe_mask,
    output logic             hit,
    input  logic             wr_en,
    input  logic             wr_replace,
    input  logic [BKT_W-1:0] wr_bkt,
    input  logic [FLT_W-1:0] wr_mask
);
    logic [FLT_W-1:0] flt [NBKT];

    for (genvar g = 0; g < NBKT; g++) begin : g_bkt
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flt[g] <= '0;
            end else if (wr_en && wr_bkt == BKT_W'(g)) begin
                flt[g] <= wr_replace ? wr_mask : (flt[g] | wr_mask);
            end
        end
    end

    assign hit = (flt[rd_bkt] & probe_mask) == probe_mask;
endmodule

// File: rtl/dedup_bf_dir.sv
// Per-bucket chain head, tail and occupancy.
module dedup_bf_dir #(
    parameter int NBKT  = 16,
    parameter int IDX_W = 6,
    localparam int BKT_W = $clog2(NBKT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BKT_W-1:0] bkt,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic             nonempty,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_head,
    input  logic [IDX_W-1:0] upd_tail,
    input  logic             upd_nonempty
);
    logic [IDX_W-1:0] head_r [NBKT];
    logic [IDX_W-1:0] tail_r [NBKT];
    logic             ne_r   [NBKT];

    for (genvar g = 0; g < NBKT; g++) begin : g_bkt
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                head_r[g] <= '0;
                tail_r[g] <= '0;
                ne_r[g]   <= 1'b0;
            end else if (upd_en && bkt == BKT_W'(g)) begin
                head_r[g] <= upd_head;
                tail_r[g] <= upd_tail;
                ne_r[g]   <= upd_nonempty;
            end
        end
    end

    assign head     = head_r[bkt];
    assign tail     = tail_r[bkt];
    assign nonempty = ne_r[bkt];
endmodule

// File: rtl/dedup_bf_engine.sv
module dedup_bf_engine
    import dedup_bf_pkg::*;
#(
    parameter int FP_W  = 32,
    parameter int NBKT  = 16,
    parameter int FLT_W = 64,
    parameter int K     = 3,
    parameter int DEPTH = 64,
    localparam int BKT_W  = $clog2(NBKT),
    localparam int POS_W  = $clog2(FLT_W),
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int WORD_W = FP_W + IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [1:0]        req_op_i,
    input  logic [FP_W-1:0]   req_fp_i,
    output logic              resp_valid_o,
    output logic [2:0]        resp_status_o,
    output logic [IDX_W-1:0]  resp_idx_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [IDX_W-1:0]  mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    input  logic [WORD_W-1:0] mem_rdata_i
);
    state_e           state_q, state_d;
    op_e              op_q;
    status_e          status_q;
    logic [FP_W-1:0]  fp_q, prev_fp_q;
    logic [IDX_W-1:0] cur_q, prev_q, mnext_q, idx_q;
    logic             prev_v_q, mlink_q;
    logic [FLT_W-1:0] shadow_q, probe_mask, rd_mask;
    logic [IDX_W:0]   alloc_q;

    logic [BKT_W-1:0] bkt;
    logic [FP_W-1:0]  rd_fp;
    logic [IDX_W-1:0] rd_next, alloc_idx;
    logic             rd_link, rd_match, bank_hit, table_full;
    logic [IDX_W-1:0] dir_head, dir_tail;
    logic             dir_ne;
    logic             walk_go, chain_end, go_alloc;
    state_e           alloc_tgt;

    logic             flt_we, flt_rep;
    logic [FLT_W-1:0] flt_wmask;
    logic             dir_we, dir_ne_w;
    logic [IDX_W-1:0] dir_head_w, dir_tail_w;

    assign bkt        = fp_q[BKT_W-1:0];
    assign rd_fp      = mem_rdata_i[FP_W-1:0];
    assign rd_next    = mem_rdata_i[FP_W +: IDX_W];
    assign rd_link    = mem_rdata_i[WORD_W-1];
    assign rd_match   = (rd_fp == fp_q);
    assign alloc_idx  = alloc_q[IDX_W-1:0];
    assign table_full = (alloc_q == (IDX_W+1)'(DEPTH));

    dedup_bf_hash #(.FLT_W(FLT_W), .K(K)) u_hash_req (
        .sel  (fp_q[BKT_W +: K*POS_W]),
        .mask (probe_mask)
    );

    dedup_bf_hash #(.FLT_W(FLT_W), .K(K)) u_hash_rd (
        .sel  (rd_fp[BKT_W +: K*POS_W]),
        .mask (rd_mask)
    );

    dedup_bf_bank #(.NBKT(NBKT), .FLT_W(FLT_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_bkt     (bkt),
        .probe_mask (probe_mask),
        .hit        (bank_hit),
        .wr_en      (flt_we),
        .wr_replace (flt_rep),
        .wr_bkt     (bkt),
        .wr_mask    (flt_wmask)
    );

    dedup_bf_dir #(.NBKT(NBKT), .IDX_W(IDX_W)) u_dir (
        .clk          (clk),
        .rst_n        (rst_n),
        .bkt          (bkt),
        .head         (dir_head),
        .tail         (dir_tail),
        .nonempty     (dir_ne),
        .upd_en       (dir_we),
        .upd_head     (dir_head_w),
        .upd_tail     (dir_tail_w),
        .upd_nonempty (dir_ne_w)
    );

    assign walk_go   = bank_hit && dir_ne;
    assign chain_end = (state_q == S_CHECK) && !rd_match && !rd_link;
    assign go_alloc  = (op_q == OP_INSERT) &&
                       (((state_q == S_PROBE) && !walk_go) || chain_end);
    assign alloc_tgt = table_full ? S_RESP : (dir_ne ? S_TAIL_RD : S_NEW_WR);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (req_valid_i) state_d = S_PROBE;
            S_PROBE: begin
                if (walk_go)                 state_d = S_FETCH;
                else if (op_q == OP_INSERT)  state_d = alloc_tgt;
                else                         state_d = S_RESP;
            end
            S_FETCH:   state_d = S_CHECK;
            S_CHECK: begin
                if (rd_match)
                    state_d = (op_q == OP_ERASE && prev_v_q) ? S_UNLINK : S_RESP;
                else if (rd_link)            state_d = S_FETCH;
                else if (op_q == OP_INSERT)  state_d = alloc_tgt;
                else                         state_d = S_RESP;
            end
            S_UNLINK:  state_d = S_RESP;
            S_TAIL_RD: state_d = S_TAIL_WR;
            S_TAIL_WR: state_d = S_NEW_WR;
            S_NEW_WR:  state_d = S_RESP;
            S_RESP:    state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // request context and walk state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q      <= OP_LOOKUP;
            fp_q      <= '0;
            cur_q     <= '0;
            prev_q    <= '0;
            prev_v_q  <= 1'b0;
            prev_fp_q <= '0;
            mlink_q   <= 1'b0;
            mnext_q   <= '0;
            shadow_q  <= '0;
            alloc_q   <= '0;
            status_q  <= ST_NEW;
            idx_q     <= '0;
        end else begin
            case (state_q)
                S_IDLE: if (req_valid_i) begin
                    op_q     <= (op_e'(req_op_i) == OP_RSVD) ? OP_LOOKUP : op_e'(req_op_i);
                    fp_q     <= req_fp_i;
                    prev_v_q <= 1'b0;
                    shadow_q <= '0;
                    idx_q    <= '0;
                end
                S_PROBE: begin
                    cur_q <= dir_head;
                    if (!walk_go) status_q <= (op_q == OP_ERASE) ? ST_NOTFOUND : ST_NEW;
                end
                S_CHECK: begin
                    shadow_q <= shadow_q | rd_mask;
                    mlink_q  <= rd_link;
                    mnext_q  <= rd_next;
                    if (rd_match) begin
                        status_q <= (op_q == OP_ERASE) ? ST_ERASED : ST_DUP;
                        idx_q    <= cur_q;
                    end else if (rd_link) begin
                        prev_q    <= cur_q;
                        prev_fp_q <= rd_fp;
                        prev_v_q  <= 1'b1;
                        cur_q     <= rd_next;
                    end else begin
                        status_q <= (op_q == OP_ERASE) ? ST_NOTFOUND : ST_NEW;
                    end
                end
                S_NEW_WR: begin
                    alloc_q  <= alloc_q + 1'b1;
                    status_q <= ST_NEW;
                    idx_q    <= alloc_idx;
                end
                default: ;
            endcase
            if (go_alloc && table_full) status_q <= ST_FULL;
        end
    end

    // outputs: memory port, filter and directory writes, handshake
    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        flt_we      = 1'b0;
        flt_rep     = 1'b0;
        flt_wmask   = '0;
        dir_we      = 1'b0;
        dir_head_w  = dir_head;
        dir_tail_w  = dir_tail;
        dir_ne_w    = dir_ne;
        unique case (state_q)
            S_PROBE: if (bank_hit && !dir_ne) begin
                flt_we  = 1'b1;
                flt_rep = 1'b1;
            end
            S_FETCH: begin
                mem_req_o  = 1'b1;
                mem_addr_o = cur_q;
            end
            S_CHECK: begin
                if (rd_match && op_q == OP_ERASE && !prev_v_q) begin
                    dir_we     = 1'b1;
                    dir_head_w = rd_next;
                    dir_ne_w   = rd_link;
                end else if (chain_end) begin
                    flt_we    = 1'b1;
                    flt_rep   = 1'b1;
                    flt_wmask = shadow_q | rd_mask;
                end
            end
            S_UNLINK: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = prev_q;
                mem_wdata_o = {mlink_q, mnext_q, prev_fp_q};
                dir_we      = 1'b1;
                dir_tail_w  = mlink_q ? dir_tail : prev_q;
                dir_ne_w    = 1'b1;
            end
            S_TAIL_RD: begin
                mem_req_o  = 1'b1;
                mem_addr_o = dir_tail;
            end
            S_TAIL_WR: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = dir_tail;
                mem_wdata_o = {1'b1, alloc_idx, rd_fp};
            end
            S_NEW_WR: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = alloc_idx;
                mem_wdata_o = {1'b0, {IDX_W{1'b0}}, fp_q};
                flt_we      = 1'b1;
                flt_wmask   = probe_mask;
                dir_we      = 1'b1;
                dir_head_w  = dir_ne ? dir_head : alloc_idx;
                dir_tail_w  = alloc_idx;
                dir_ne_w    = 1'b1;
            end
            default: ;
        endcase
    end

    assign req_ready_o   = (state_q == S_IDLE);
    assign resp_valid_o  = (state_q == S_RESP);
    assign resp_status_o = status_q;
    assign resp_idx_o    = idx_q;
endmodule

// File: rtl/dedup_bf_engine_chk.sv
module dedup_bf_engine_chk
    import dedup_bf_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready_o,
    input logic       resp_valid_o,
    input logic [2:0] resp_status_o,
    input logic       mem_req_o,
    input logic       mem_we_o,
    input state_e     state_q,
    input op_e        op_q,
    input logic       bank_hit
);
    // R9: idle engine touches neither memory nor the response strobe
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> (!mem_req_o && !resp_valid_o));

    // R9: response lasts one cycle and the engine is ready right after
    assert_resp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid_o |=> (!resp_valid_o && req_ready_o));

    // R9: a lookup never writes memory
    assert_lookup_nowrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready_o && op_q == OP_LOOKUP) |-> !mem_we_o);

    // R3: a filter miss on lookup or erase goes straight to a response with no read
    assert_miss_noread_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PROBE && !bank_hit && op_q != OP_INSERT) |=> (!mem_req_o && resp_valid_o));

    // R8: an erase answers only ERASED or NOTFOUND
    assert_erase_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid_o && op_q == OP_ERASE) |->
            (resp_status_o == ST_ERASED || resp_status_o == ST_NOTFOUND));

    // R7: FULL only ever answers an insert
    assert_full_insert_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid_o && resp_status_o == ST_FULL) |-> (op_q == OP_INSERT));
endmodule

bind dedup_bf_engine dedup_bf_engine_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready_o   (req_ready_o),
    .resp_valid_o  (resp_valid_o),
    .resp_status_o (resp_status_o),
    .mem_req_o     (mem_req_o),
    .mem_we_o      (mem_we_o),
    .state_q       (state_q),
    .op_q          (op_q),
    .bank_hit      (bank_hit)
);

// File: tb/dedup_bf_engine_tb.sv
module dedup_bf_engine_tb;
    localparam int FP_W = 32, NB = 16, DEPTH = 64, IDX_W = 6;
    localparam int WORD_W = FP_W + IDX_W + 1;

    logic              clk = 1'b0, rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [1:0]        req_op = '0;
    logic [FP_W-1:0]   req_fp = '0;
    logic              req_ready, resp_valid, mem_req, mem_we;
    logic [2:0]        resp_status;
    logic [IDX_W-1:0]  resp_idx, mem_addr;
    logic [WORD_W-1:0] mem_wdata, mem_rdata;
    logic [WORD_W-1:0] mem [DEPTH];

    int n_chk = 0, n_fail = 0, rd_cnt = 0, cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    dedup_bf_engine u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_op_i(req_op), .req_fp_i(req_fp),
        .resp_valid_o(resp_valid), .resp_status_o(resp_status), .resp_idx_o(resp_idx),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
    );

    // R11: memory model, read data one cycle after the request
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata     <= mem[mem_addr];
        end
    end
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req && !mem_we) rd_cnt <= rd_cnt + 1;
    end

    // reference model
    logic [FP_W-1:0]  m_fp  [NB][DEPTH];
    int               m_idx [NB][DEPTH];
    int               m_len [NB];
    logic [63:0]      m_flt [NB];
    int               m_alloc = 0;

    function automatic logic [63:0] f_mask(input logic [FP_W-1:0] fp);
        logic [63:0] m = '0;
        m[fp[9:4]]   = 1'b1;
        m[fp[15:10]] = 1'b1;
        m[fp[21:16]] = 1'b1;
        return m;
    endfunction

    function automatic logic [FP_W-1:0] mk_fp(input int hi, input int p2, input int p1,
                                              input int p0, input int b);
        return {10'(hi), 6'(p2), 6'(p1), 6'(p0), 4'(b)};
    endfunction

    task automatic model_op(input int op, input logic [FP_W-1:0] fp,
                            output int st, output int idx, output int rd);
        int b = int'(fp[3:0]);
        logic [63:0] m = f_mask(fp), sh = '0;
        int found = -1;
        int eop = (op == 3) ? 0 : op;
        rd = 0; idx = 0; st = 0;
        if ((m_flt[b] & m) == m) begin
            for (int i = 0; i < m_len[b]; i++) begin
                rd++;
                sh = sh | f_mask(m_fp[b][i]);
                if (m_fp[b][i] == fp) begin found = i; break; end
            end
            if (found < 0) m_flt[b] = sh;
        end
        if (found >= 0) begin
            idx = m_idx[b][found];
            if (eop == 2) begin
                st = 2;
                for (int i = found; i < m_len[b] - 1; i++) begin
                    m_fp[b][i]  = m_fp[b][i+1];
                    m_idx[b][i] = m_idx[b][i+1];
                end
                m_len[b]--;
            end else st = 1;
        end else if (eop == 2) st = 3;
        else if (eop == 0) st = 0;
        else if (m_alloc == DEPTH) st = 4;
        else begin
            if (m_len[b] > 0) rd++;
            m_fp[b][m_len[b]]  = fp;
            m_idx[b][m_len[b]] = m_alloc;
            m_len[b]++;
            m_flt[b] = m_flt[b] | m;
            st = 0; idx = m_alloc;
            m_alloc++;
        end
    endtask

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic run_op(input int op, input logic [FP_W-1:0] fp, input string tag);
        int e_st, e_idx, e_rd, base, a_st, a_idx;
        model_op(op, fp, e_st, e_idx, e_rd);
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'(op); req_fp = fp;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        base = rd_cnt;
        while (!resp_valid) @(negedge clk);
        a_st = int'(resp_status); a_idx = int'(resp_idx);
        chk(a_st == e_st, tag, "status", a_st, e_st);
        chk(rd_cnt - base == e_rd, tag, "reads", rd_cnt - base, e_rd);
        if (e_st == 1 || e_st == 2 || (op == 1 && e_st == 0))
            chk(a_idx == e_idx, tag, "index", a_idx, e_idx);
    endtask

    initial begin
        for (int b = 0; b < NB; b++) begin m_len[b] = 0; m_flt[b] = '0; end
    end

    // watchdog
    initial begin
        wait (cyc > 150000 || done);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R9 watchdog: actual %0d cycles expected completion", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [FP_W-1:0] pool [24];
        logic [FP_W-1:0] fa, fb, fc, ff, fd;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
        chk(resp_valid == 1'b0, "R1", "resp after reset", int'(resp_valid), 0);
        chk(mem_req == 1'b0, "R1", "mem idle in reset", int'(mem_req), 0);
        rst_n = 1'b1;

        fa = mk_fp(1, 3, 2, 1, 5);
        fb = mk_fp(2, 9, 8, 7, 5);
        fc = mk_fp(1, 3, 2, 1, 6);
        ff = mk_fp(7, 3, 2, 1, 5);
        fd = mk_fp(3, 12, 11, 10, 5);
        run_op(0, fa, "R1");          // empty filters: NEW with no reads
        run_op(2, fa, "R3");          // erase miss: NOTFOUND, no reads
        run_op(1, fa, "R6");          // insert into empty bucket: idx 0
        run_op(0, fa, "R4");          // DUP idx 0, one read
        run_op(1, fb, "R6");          // append: one tail read
        run_op(1, fd, "R6");          // append third entry
        run_op(0, fc, "R2");          // other bucket, same positions: no walk
        run_op(0, fd, "R4");          // walk to third entry
        run_op(0, ff, "R5");          // false positive: full walk, rebuild
        run_op(3, fb, "R10");         // code 3 acts as lookup
        run_op(2, fb, "R8");          // erase middle entry (unlink via predecessor)
        run_op(0, fd, "R11");         // chain relinked: two reads reach fd
        run_op(2, fa, "R8");          // erase head
        run_op(0, fa, "R8");          // stale bits: still walks, then rebuild
        run_op(0, fa, "R5");          // rebuilt filter: no reads
        run_op(2, fd, "R8");          // erase last entry, bucket empty
        run_op(1, fd, "R6");          // reinsert into emptied bucket, fresh index
        @(negedge clk);
        chk(req_ready == 1'b1 && resp_valid == 1'b0, "R9", "ready after response",
            int'(req_ready), 1);

        for (int i = 0; i < 24; i++)
            pool[i] = mk_fp(int'($urandom % 1024), int'($urandom % 3), int'($urandom % 3),
                            int'($urandom % 3), int'($urandom % 4));
        for (int n = 0; n < 300; n++) begin
            int r = int'($urandom % 10);
            int op = (r < 4) ? 1 : (r < 7) ? 0 : (r < 9) ? 2 : 3;
            run_op(op, pool[$urandom % 24], "R4");
        end

        for (int i = 0; m_alloc < DEPTH && i < 200; i++)
            run_op(1, mk_fp(512 + i, i % 64, (i / 2) % 64, (i * 5) % 64, 8 + (i % 8)), "R6");
        run_op(1, mk_fp(1000, 40, 41, 42, 9), "R7");   // table full
        run_op(0, mk_fp(1000, 40, 41, 42, 9), "R7");   // nothing was added

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule